// File: doc/BRIEF.md
# Variable-pulse-width frame transmitter

This block turns a short message into a single-wire variable-pulse-width waveform. Message bytes arrive on a valid/ready byte stream, with a flag on the final byte. They are stored locally while a CRC byte is built over them. Once the final byte is taken, the block drives the transmit line through a fixed sequence: a start-of-frame high pulse, every stored byte, the CRC byte, and a low end-of-frame interval. All durations are counted in pulses of a one-microsecond tick strobe, not in clock cycles. A speed input divides every duration by four for the faster bus rate.

Each bit is one symbol, and the line level alternates from one symbol to the next. A symbol lasts either a short or a long time, and which one depends on both the bit value and the level the symbol sits at. The receive output either passes through the level seen on the bus or, with loopback selected, copies the transmit line. The block raises a one-cycle done pulse when the frame completes, and a one-cycle overflow pulse when a message is too long to send.

Top module: `vpw_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is low, `busy` is low, `s_ready` is high, and `done` and `overflow` are low.
- R2: The cycle after the final byte is accepted, a start request is registered. One edge later `tx_line` goes high, and it stays high for 200 tick pulses.
- R3: After the start pulse, each byte is sent most significant bit first, one symbol per bit. The first symbol is low and the level flips at every symbol boundary. A symbol is long (128 ticks) when the bit equals the line level (1 sent high, 0 sent low) and short (64 ticks) otherwise.
- R4: After the last data byte, one more byte is sent with the same encoding. It is the bitwise inverse of a CRC-8 with polynomial 0x1D, register preset to 0xFF, processed MSB first over the data bytes only.
- R5: After the last symbol the line is low for 280 ticks. Then `done` is high for exactly one cycle, and `busy` is low in the following cycle.
- R6: `busy` rises the cycle after the first byte is accepted. From acceptance of the final byte until `busy` falls, `s_ready` is low and no byte is taken.
- R7: When `fast_mode` is high at the moment the frame starts, every duration (start, short, long, end) is one quarter of its normal value. A change of `fast_mode` during a frame has no effect on that frame.
- R8: If a 13th byte is accepted, `overflow` pulses for one cycle. No frame is sent, all bytes up to and including the one flagged last are taken and discarded, and `busy` then falls.
- R9: Symbol durations count `us_tick` pulses only, so a tick every N clocks stretches the waveform by N in clock time while tick counts stay the same.
- R10: With `loop_en` high, `rx_out` equals `tx_line`. With `loop_en` low, `rx_out` equals `bus_rx_in`.
- R11: Frames of 1 to 12 bytes are sent, with the bytes in acceptance order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| fast_mode | input | 1 | Quarter-length symbols when high at frame start |
| loop_en | input | 1 | Route the transmit level to `rx_out` |
| bus_rx_in | input | 1 | Level received from the bus |
| s_valid | input | 1 | Byte stream valid |
| s_data | input | 8 | Byte stream data |
| s_last | input | 1 | Marks the final byte of a message |
| s_ready | output | 1 | Byte stream ready |
| tx_line | output | 1 | Transmit line level |
| rx_out | output | 1 | Receive output toward the host |
| busy | output | 1 | Message in progress |
| done | output | 1 | One-cycle pulse at end of frame |
| overflow | output | 1 | One-cycle pulse on a too-long message |

## Verification
Two events can land on the same clock edge: the end of the low end-of-frame interval, and the arrival of the next message's first byte. The bench provokes this by offering the next message back to back. The byte is held valid while the previous frame finishes, so the first byte is presented on the very cycle `done` fires. The new byte must be taken only after `busy` has dropped. The new frame must decode to its own bytes and CRC, and the previous frame's low end interval must still measure its full length. A second collision comes from the vector that flips `fast_mode` between symbols, and that frame is judged by decoding it at the speed latched at its start.

// File: rtl/vpw_tx_pkg.sv
package vpw_tx_pkg;

  typedef enum logic [1:0] {
    COL_IDLE,
    COL_FILL,
    COL_DRAIN,
    COL_HOLD
  } col_state_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_SOF,
    SEQ_BITS,
    SEQ_EOF
  } seq_state_e;

  // One byte through a CRC-8 register, MSB first.
  function automatic logic [7:0] crc8_next(input logic [7:0] crc,
                                           input logic [7:0] data,
                                           input logic [7:0] poly);
    logic [7:0] c;
    c = crc ^ data;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ poly) : (c << 1);
    end
    return c;
  endfunction

  // Long symbol when the bit value matches the level it is sent at.
  function automatic logic sym_is_long(input logic bit_val, input logic level);
    return bit_val == level;
  endfunction

endpackage

// File: rtl/vpw_byte_collect.sv
module vpw_byte_collect
  import vpw_tx_pkg::*;
#(
  parameter int         MAX_BYTES = 12,
  parameter logic [7:0] CRC_POLY  = 8'h1D,
  parameter int         IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  output logic             s_ready,
  output logic             frame_go,
  output logic             overflow,
  output logic             busy,
  input  logic             tx_done,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] nbytes,
  output logic [7:0]       rd_byte
);

  localparam logic [IDX_W-1:0] FULL = IDX_W'(MAX_BYTES);

  col_state_e       st_q;
  logic [IDX_W-1:0] cnt_q;
  logic [7:0]       crc_q;
  logic [7:0]       store_q [MAX_BYTES];

  logic beat;
  logic filling;
  logic store_en;

  assign s_ready  = (st_q != COL_HOLD);
  assign busy     = (st_q != COL_IDLE);
  assign beat     = s_valid && s_ready;
  assign filling  = (st_q == COL_IDLE) || (st_q == COL_FILL);
  assign store_en = beat && filling && (cnt_q != FULL);
  assign nbytes   = cnt_q;

  always_ff @(posedge clk) begin
    for (int i = 0; i < MAX_BYTES; i++) begin
      if (store_en && cnt_q == IDX_W'(i)) store_q[i] <= s_data;
    end
  end

  always_comb begin
    rd_byte = ~crc_q;
    for (int i = 0; i < MAX_BYTES; i++) begin
      if (rd_idx == IDX_W'(i) && rd_idx != cnt_q) rd_byte = store_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= COL_IDLE;
      cnt_q    <= '0;
      crc_q    <= 8'hFF;
      frame_go <= 1'b0;
      overflow <= 1'b0;
    end else begin
      frame_go <= 1'b0;
      overflow <= 1'b0;
      case (st_q)
        COL_IDLE, COL_FILL: begin
          if (beat) begin
            if (cnt_q == FULL) begin
              overflow <= 1'b1;
              cnt_q    <= '0;
              crc_q    <= 8'hFF;
              st_q     <= s_last ? COL_IDLE : COL_DRAIN;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              crc_q <= crc8_next(crc_q, s_data, CRC_POLY);
              if (s_last) begin
                st_q     <= COL_HOLD;
                frame_go <= 1'b1;
              end else begin
                st_q <= COL_FILL;
              end
            end
          end
        end
        COL_DRAIN: begin
          if (beat && s_last) st_q <= COL_IDLE;
        end
        COL_HOLD: begin
          if (tx_done) begin
            st_q  <= COL_IDLE;
            cnt_q <= '0;
            crc_q <= 8'hFF;
          end
        end
        default: st_q <= COL_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vpw_sym_timer.sv
module vpw_sym_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] dur,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  assign expire = run && tick && (cnt_q == dur - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= expire ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/vpw_bit_seq.sv
module vpw_bit_seq
  import vpw_tx_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int CNT_W    = 9,
  parameter int SOF_US   = 200,
  parameter int SHORT_US = 64,
  parameter int LONG_US  = 128,
  parameter int EOF_US   = 280,
  parameter int FAST_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_go,
  input  logic             fast_mode,
  input  logic [IDX_W-1:0] nbytes,
  input  logic [7:0]       rd_byte,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             expire,
  output logic             run,
  output logic [CNT_W-1:0] dur,
  output logic             tx_line,
  output logic             tx_done
);

  localparam logic [CNT_W-1:0] SOF_N   = CNT_W'(SOF_US);
  localparam logic [CNT_W-1:0] SHORT_N = CNT_W'(SHORT_US);
  localparam logic [CNT_W-1:0] LONG_N  = CNT_W'(LONG_US);
  localparam logic [CNT_W-1:0] EOF_N   = CNT_W'(EOF_US);
  localparam logic [CNT_W-1:0] SOF_F   = CNT_W'(SOF_US / FAST_DIV);
  localparam logic [CNT_W-1:0] SHORT_F = CNT_W'(SHORT_US / FAST_DIV);
  localparam logic [CNT_W-1:0] LONG_F  = CNT_W'(LONG_US / FAST_DIV);
  localparam logic [CNT_W-1:0] EOF_F   = CNT_W'(EOF_US / FAST_DIV);

  seq_state_e       st_q;
  logic             fast_q;
  logic             line_q;
  logic [IDX_W-1:0] byte_q;
  logic [2:0]       bit_q;
  logic             cur_bit;
  logic             last_bit;

  assign rd_idx   = byte_q;
  assign cur_bit  = rd_byte[bit_q];
  assign run      = (st_q != SEQ_IDLE);
  assign tx_line  = line_q;
  assign last_bit = (bit_q == 3'd0) && (byte_q == nbytes);

  always_comb begin
    case (st_q)
      SEQ_SOF:  dur = fast_q ? SOF_F : SOF_N;
      SEQ_BITS: begin
        if (sym_is_long(cur_bit, line_q)) dur = fast_q ? LONG_F : LONG_N;
        else                              dur = fast_q ? SHORT_F : SHORT_N;
      end
      default:  dur = fast_q ? EOF_F : EOF_N;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      fast_q  <= 1'b0;
      line_q  <= 1'b0;
      byte_q  <= '0;
      bit_q   <= 3'd7;
      tx_done <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      case (st_q)
        SEQ_IDLE: begin
          if (frame_go) begin
            st_q   <= SEQ_SOF;
            fast_q <= fast_mode;
            line_q <= 1'b1;
            byte_q <= '0;
            bit_q  <= 3'd7;
          end
        end
        SEQ_SOF: begin
          if (expire) begin
            st_q   <= SEQ_BITS;
            line_q <= 1'b0;
          end
        end
        SEQ_BITS: begin
          if (expire) begin
            line_q <= ~line_q;
            if (last_bit) begin
              st_q <= SEQ_EOF;
            end else if (bit_q == 3'd0) begin
              byte_q <= byte_q + 1'b1;
              bit_q  <= 3'd7;
            end else begin
              bit_q <= bit_q - 1'b1;
            end
          end
        end
        SEQ_EOF: begin
          if (expire) begin
            st_q    <= SEQ_IDLE;
            tx_done <= 1'b1;
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vpw_tx.sv
module vpw_tx #(
  parameter int         MAX_BYTES = 12,
  parameter int         SOF_US    = 200,
  parameter int         SHORT_US  = 64,
  parameter int         LONG_US   = 128,
  parameter int         EOF_US    = 280,
  parameter int         FAST_DIV  = 4,
  parameter logic [7:0] CRC_POLY  = 8'h1D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       fast_mode,
  input  logic       loop_en,
  input  logic       bus_rx_in,
  input  logic       s_valid,
  input  logic [7:0] s_data,
  input  logic       s_last,
  output logic       s_ready,
  output logic       tx_line,
  output logic       rx_out,
  output logic       busy,
  output logic       done,
  output logic       overflow
);

  localparam int IDX_W  = $clog2(MAX_BYTES + 1);
  localparam int MAX_A  = (SOF_US > EOF_US) ? SOF_US : EOF_US;
  localparam int MAX_US = (MAX_A > LONG_US) ? MAX_A : LONG_US;
  localparam int CNT_W  = $clog2(MAX_US + 1);

  // Named internal events, observed by the bound checker.
  logic             frame_go;
  logic             sym_end;
  logic             tmr_run;
  logic [CNT_W-1:0] sym_dur;
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] nbytes;
  logic [7:0]       rd_byte;

  vpw_byte_collect #(
    .MAX_BYTES(MAX_BYTES),
    .CRC_POLY (CRC_POLY),
    .IDX_W    (IDX_W)
  ) u_collect (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_data  (s_data),
    .s_last  (s_last),
    .s_ready (s_ready),
    .frame_go(frame_go),
    .overflow(overflow),
    .busy    (busy),
    .tx_done (done),
    .rd_idx  (rd_idx),
    .nbytes  (nbytes),
    .rd_byte (rd_byte)
  );

  vpw_sym_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (tmr_run),
    .tick  (us_tick),
    .dur   (sym_dur),
    .expire(sym_end)
  );

  vpw_bit_seq #(
    .IDX_W   (IDX_W),
    .CNT_W   (CNT_W),
    .SOF_US  (SOF_US),
    .SHORT_US(SHORT_US),
    .LONG_US (LONG_US),
    .EOF_US  (EOF_US),
    .FAST_DIV(FAST_DIV)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_go (frame_go),
    .fast_mode(fast_mode),
    .nbytes   (nbytes),
    .rd_byte  (rd_byte),
    .rd_idx   (rd_idx),
    .expire   (sym_end),
    .run      (tmr_run),
    .dur      (sym_dur),
    .tx_line  (tx_line),
    .tx_done  (done)
  );

  assign rx_out = loop_en ? tx_line : bus_rx_in;

endmodule

// File: rtl/vpw_tx_chk.sv
module vpw_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic us_tick,
  input logic loop_en,
  input logic bus_rx_in,
  input logic tx_line,
  input logic rx_out,
  input logic busy,
  input logic done,
  input logic overflow,
  input logic s_ready,
  input logic frame_go,
  input logic sym_end
);

  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_line);

  a_r2_sof_rise: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go |=> tx_line);

  a_r9_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(tx_line) && !$past(frame_go)) |-> $past(us_tick));

  a_r9_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    sym_end |-> us_tick);

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r5_eof_low: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_line);

  a_r6_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_line || frame_go) |-> !s_ready);

  a_r8_ovf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (!tx_line && !done));

  a_r10_loop_tx: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (rx_out == tx_line));

  a_r10_loop_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |-> (rx_out == bus_rx_in));

endmodule

bind vpw_tx vpw_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .us_tick  (us_tick),
  .loop_en  (loop_en),
  .bus_rx_in(bus_rx_in),
  .tx_line  (tx_line),
  .rx_out   (rx_out),
  .busy     (busy),
  .done     (done),
  .overflow (overflow),
  .s_ready  (s_ready),
  .frame_go (frame_go),
  .sym_end  (sym_end)
);

// File: tb/vpw_tx_tb.sv
module vpw_tx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int T_SOF = 200;
  localparam int T_SHORT = 64;
  localparam int T_LONG = 128;
  localparam int T_EOF = 280;
  localparam int WD_LIMIT = 150000;

  // Vector layout: [103:100] byte count, [99] fast, [98:97] tick divider,
  // [96] flip fast_mode mid-frame, [95:0] bytes, first byte at the top.
  localparam logic [103:0] VECS [8] = '{
    {4'd1,  1'b0, 2'd1, 1'b0, 96'h0},
    {4'd1,  1'b1, 2'd1, 1'b0, 8'hFF, 88'h0},
    {4'd3,  1'b0, 2'd2, 1'b0, 8'hA5, 8'h5A, 8'h3C, 72'h0},
    {4'd9,  1'b0, 2'd1, 1'b0, 8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39, 24'h0},
    {4'd12, 1'b1, 2'd1, 1'b0, 96'h00112233445566778899AABB},
    {4'd2,  1'b1, 2'd3, 1'b0, 8'h80, 8'h01, 80'h0},
    {4'd12, 1'b0, 2'd1, 1'b0, 96'hF0E1D2C3B4A5968778695A4B},
    {4'd4,  1'b0, 2'd1, 1'b1, 8'hDE, 8'hAD, 8'hBE, 8'hEF, 64'h0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       us_tick = 1'b0;
  logic       fast_mode = 1'b0;
  logic       loop_en = 1'b0;
  logic       bus_rx_in = 1'b0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_last = 1'b0;
  logic       s_ready, tx_line, rx_out, busy, done, overflow;

  int n_checks = 0;
  int n_errors = 0;
  int tdiv = 1;
  int cyc = 0;

  // Monitor state
  logic   run_lv [128];
  int     run_len [128];
  int     nrun = 0;
  int     run = 0;
  logic   prev_lv = 1'b0;
  int     done_cnt = 0;
  int     ovf_cnt = 0;
  int     eof_meas = 0;
  bit     saw_high = 1'b0;
  logic [7:0] msg [12];

  vpw_tx u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .us_tick  (us_tick),
    .fast_mode(fast_mode),
    .loop_en  (loop_en),
    .bus_rx_in(bus_rx_in),
    .s_valid  (s_valid),
    .s_data   (s_data),
    .s_last   (s_last),
    .s_ready  (s_ready),
    .tx_line  (tx_line),
    .rx_out   (rx_out),
    .busy     (busy),
    .done     (done),
    .overflow (overflow)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin : tick_gen
    int tc;
    tc = 0;
    forever begin
      @(posedge clk);
      us_tick <= (tc + 1 >= tdiv);
      tc = (tc + 1 >= tdiv) ? 0 : tc + 1;
    end
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (tx_line !== prev_lv) begin
      if (nrun > 0 || prev_lv) begin
        if (nrun < 128) begin
          run_lv[nrun]  = prev_lv;
          run_len[nrun] = run;
        end
        nrun = nrun + 1;
      end
      run = 0;
      prev_lv = tx_line;
    end
    if (done) begin
      done_cnt = done_cnt + 1;
      eof_meas = run;
    end
    if (overflow) ovf_cnt = ovf_cnt + 1;
    if (tx_line) saw_high = 1'b1;
    if (us_tick) run = run + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_errors = n_errors + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // Watchdog: an expired limit is a failed check.
  initial begin
    wait (cyc >= WD_LIMIT);
    chk(1'b0, "WDOG", "run did not finish", cyc, WD_LIMIT);
    finish_run();
  end

  function automatic logic [7:0] ref_crc(input int n);
    logic [7:0] r;
    logic fb;
    r = 8'hFF;
    for (int i = 0; i < n * 8; i++) begin
      fb = r[7] ^ msg[i / 8][7 - (i % 8)];
      r  = {r[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
    end
    return ~r;
  endfunction

  task automatic mon_clear();
    nrun = 0;
    done_cnt = 0;
    ovf_cnt = 0;
    saw_high = 1'b0;
    eof_meas = 0;
  endtask

  task automatic put_byte(input logic [7:0] d, input bit last);
    bit acc;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = d;
      s_last  = last;
      acc     = s_ready;
      @(posedge clk);
    end
  endtask

  task automatic drop_valid();
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic wait_done();
    int w;
    w = 0;
    while (done_cnt == 0 && w < 40000) begin
      @(posedge clk);
      w = w + 1;
    end
  endtask

  task automatic decode_frame(input int n, input bit fast, input int td);
    int div, need, sht, lng;
    bit alt_bad;
    logic [7:0] crc;
    div = fast ? 4 : 1;
    sht = T_SHORT / div;
    lng = T_LONG / div;
    need = 1 + 8 * (n + 1);
    alt_bad = 1'b0;
    crc = ref_crc(n);
    chk(done_cnt == 1, "R5", "done pulses", done_cnt, 1);
    chk(eof_meas == T_EOF / div, "R5", "end-of-frame low ticks", eof_meas, T_EOF / div);
    chk(nrun == need, "R11", "symbol run count", nrun, need);
    if (nrun == need) begin
      chk(run_lv[0] == 1'b1 && run_len[0] == T_SOF / div,
          (td > 1) ? "R9" : "R2", "start pulse ticks", run_len[0], T_SOF / div);
      for (int b = 0; b <= n; b++) begin
        logic [7:0] got;
        logic [7:0] exp;
        bit bad;
        got = 8'h00;
        bad = 1'b0;
        for (int j = 0; j < 8; j++) begin
          int k;
          logic bv;
          k = 1 + 8 * b + j;
          if (run_lv[k] != ((k % 2) == 0)) alt_bad = 1'b1;
          if (run_len[k] == lng)      bv = run_lv[k];
          else if (run_len[k] == sht) bv = ~run_lv[k];
          else begin
            bv = 1'b0;
            bad = 1'b1;
          end
          got = {got[6:0], bv};
        end
        exp = (b < n) ? msg[b] : crc;
        chk(!bad && got == exp, (b < n) ? "R3" : "R4",
            (b < n) ? "data byte" : "crc byte", got, exp);
      end
      chk(!alt_bad, "R3", "level alternation", alt_bad, 0);
    end
  endtask

  task automatic run_frame(input int n, input bit fast, input int td, input bit flip);
    tdiv = td;
    fast_mode = fast;
    mon_clear();
    for (int i = 0; i < n; i++) put_byte(msg[i], i == n - 1);
    drop_valid();
    // R6: final byte taken, frame owns the block
    chk(busy == 1'b1 && s_ready == 1'b0, "R6", "busy/ready during frame",
        {busy, s_ready}, 2'b10);
    if (flip) begin
      repeat (T_SOF * td + 30) @(negedge clk);
      fast_mode = ~fast;  // R7: must not affect this frame
    end
    wait_done();
    @(negedge clk);
    chk(busy == 1'b0 && s_ready == 1'b1, "R5", "busy after done",
        {busy, s_ready}, 2'b01);
    decode_frame(n, fast, td);
    fast_mode = 1'b0;
    tdiv = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk({tx_line, busy, s_ready, done, overflow} == 5'b00100, "R1", "idle outputs",
        {tx_line, busy, s_ready, done, overflow}, 5'b00100);

    // R4: reference CRC anchored on a known message
    for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    chk(ref_crc(9) == 8'h4B, "R4", "bench crc anchor", ref_crc(9), 8'h4B);

    // Vector table: R2 R3 R4 R5 R7 R9 R11
    for (int v = 0; v < 8; v++) begin
      int n;
      for (int i = 0; i < 12; i++) msg[i] = VECS[v][95 - 8 * i -: 8];
      n = int'(VECS[v][103:100]);
      run_frame(n, VECS[v][99], int'(VECS[v][98:97]), VECS[v][96]);
    end

    // R6 / R5: back-to-back frames, next first byte held during end interval
    msg[0] = 8'h12; msg[1] = 8'h34;
    mon_clear();
    put_byte(8'h12, 1'b0);
    put_byte(8'h34, 1'b1);
    @(negedge clk);
    s_valid = 1'b1; s_data = 8'h77; s_last = 1'b1;
    wait_done();
    decode_frame(2, 1'b0, 1);
    mon_clear();
    msg[0] = 8'h77;
    put_byte(8'h77, 1'b1);
    drop_valid();
    wait_done();
    decode_frame(1, 1'b0, 1);
    @(negedge clk);

    // R10: loopback and pass-through
    msg[0] = 8'h55;
    loop_en = 1'b1;
    bus_rx_in = 1'b0;
    mon_clear();
    put_byte(8'h55, 1'b1);
    drop_valid();
    repeat (5) @(negedge clk);
    chk(rx_out == 1'b1 && tx_line == 1'b1, "R10", "loopback copies tx", rx_out, 1);
    loop_en = 1'b0;
    @(negedge clk);
    chk(rx_out == 1'b0, "R10", "pass-through low bus", rx_out, 0);
    bus_rx_in = 1'b1;
    @(negedge clk);
    chk(rx_out == 1'b1, "R10", "pass-through high bus", rx_out, 1);
    bus_rx_in = 1'b0;
    wait_done();
    @(negedge clk);

    // R8: overflow with the last flag on the 14th byte
    mon_clear();
    for (int i = 0; i < 13; i++) put_byte(8'(i), 1'b0);
    put_byte(8'hEE, 1'b1);
    drop_valid();
    repeat (300) @(negedge clk);
    chk(ovf_cnt == 1, "R8", "overflow pulses", ovf_cnt, 1);
    chk(!saw_high && done_cnt == 0, "R8", "no frame after overflow", saw_high, 0);
    chk(busy == 1'b0 && s_ready == 1'b1, "R8", "idle after drain", {busy, s_ready}, 2'b01);

    // R8: overflow when the 13th byte carries the last flag
    mon_clear();
    for (int i = 0; i < 12; i++) put_byte(8'hA0 + 8'(i), 1'b0);
    put_byte(8'hAC, 1'b1);
    drop_valid();
    repeat (300) @(negedge clk);
    chk(ovf_cnt == 1 && !saw_high, "R8", "13th byte last", ovf_cnt, 1);
    chk(busy == 1'b0, "R8", "busy after 13th", busy, 0);

    // Block usable again after overflow (R11)
    msg[0] = 8'hC3;
    run_frame(1, 1'b0, 1, 1'b0);

    finish_run();
  end

endmodule